// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset Controller

This block supervises a microprocessor system and runs from one synchronous clock. An external comparator reports supply health as `pwr_ok`, and `on_batt` marks operation from the backup source. From these two flags the block forms a low-line flag. It holds the processor in reset while the supply is bad, and it keeps that reset asserted for a programmable hold time once the supply recovers. It also blocks writes to backed-up memory by forcing the memory chip enable inactive.

A watchdog watches `wd_in`. Any transition of that input, rising or falling, restarts the watchdog counter. If no transition arrives within the timeout, the watchdog output drops and a full reset pulse is issued. While the watchdog stays unserviced, this repeats once per timeout period. The input is a digital stand-in for a three-level pin. For that reason a separate enable, `wd_en`, stands for the "input left open" case, and clearing it stops all timeouts.

All timing is counted in ticks of an internal prescaler that divides the clock by `PRESCALE_DIV`. The timeout can be long or short. The first timeout after any reset always uses the long value. A power-fail warning input passes through to its output, except in battery mode, where that output is pulled low. The block has no data stream, so every pin is a plain level signal.

Top module: `supv_ctrl`

## Requirements
- R1: While `pwr_ok`=0 or `on_batt`=1, the reset is asserted at once (`sys_rst_n`=0, `sys_rst`=1) and `low_line_n`=0. `sys_rst` is always the inverse of `sys_rst_n`, and `low_line_n` = `pwr_ok` AND NOT `on_batt`.
- R2: Once the supply becomes good, the reset releases on the `RST_ACT_TICKS`-th prescaler tick. A tick occurs every `PRESCALE_DIV` cycles, so the release comes at least (`RST_ACT_TICKS`-1)·`PRESCALE_DIV`+1 and at most `RST_ACT_TICKS`·`PRESCALE_DIV` cycles after the first clock edge that sees the good supply.
- R3: `wd_in` passes through two synchroniser flops, and a transition restarts the counter on the third clock edge after it. If `WD_LONG_TICKS` ticks then pass with no transition, `wdog_ok` goes to 0 and the reset asserts on the same edge.
- R4: While the watchdog is enabled and unserviced, it expires again exactly one long period (`WD_LONG_TICKS`·`PRESCALE_DIV` cycles) after each expiry, and each expiry starts a new reset pulse.
- R5: `wdog_ok` returns to 1 on the third edge after a `wd_in` transition, or on the first edge on which `low_line_n` is 0. It changes state for no other cause.
- R6: With `wd_short`=1, a serviced watchdog (serviced while reset is released) times out after `WD_SHORT_TICKS` ticks. After any reset, whether from an expiry, a supply loss or `rst`, the long period applies until the next transition seen outside reset.
- R7: While `wd_en`=0, the watchdog never expires.
- R8: `mem_ce_n` equals `ce_in_n` while `low_line_n`=1, and is 1 otherwise.
- R9: `pfail_n` equals `pf_in` when `on_batt`=0 and is 0 when `on_batt`=1. In battery mode, `wd_in` transitions affect no output.
- R10: The synchronous `rst` asserts the reset and sets `wdog_ok`=1. It also resets the prescaler phase and arms the long period. After `rst` falls, with the supply good, the release comes exactly `RST_ACT_TICKS`·`PRESCALE_DIV` edges later, and an unserviced watchdog expires exactly `WD_LONG_TICKS`·`PRESCALE_DIV` edges after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| pwr_ok | input | 1 | Supply above threshold (comparator result) |
| on_batt | input | 1 | Backup source is powering the system |
| wd_in | input | 1 | Watchdog service input, toggled by software |
| wd_en | input | 1 | Watchdog enabled (0 = input left open) |
| wd_short | input | 1 | Select the short timeout period |
| ce_in_n | input | 1 | Memory chip enable from the address decoder, active low |
| pf_in | input | 1 | Power-fail comparator result, 1 = healthy |
| sys_rst_n | output | 1 | Processor reset, active low |
| sys_rst | output | 1 | Processor reset, active high |
| wdog_ok | output | 1 | Watchdog status, 0 after a timeout |
| low_line_n | output | 1 | Low-line flag, 0 when the supply is bad or in battery mode |
| mem_ce_n | output | 1 | Gated memory chip enable, active low |
| pfail_n | output | 1 | Power-fail warning, active low |

## Verification
The gating outputs `mem_ce_n`, `pfail_n`, `low_line_n` and the assertion of reset on supply loss are combinational. The bench checks them a few nanoseconds after it drives the inputs, with no clock edge in between. The watchdog status reacts on the third edge after a `wd_in` change, because of the two synchroniser stages and the edge flop. The bench samples it after the second edge and again after the third.

Reset release and watchdog expiry fall on prescaler ticks, and the tick phase is free-running. Those results are therefore checked against the R2/R3 windows one prescale period wide, by counting edges until the output changes. Where the phase is fixed, the bench expects an exact edge count: the gap between two expiries in a row, and the cycles that follow `rst`.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic {
    PER_LONG  = 1'b0,
    PER_SHORT = 1'b1
  } wd_period_e;
endpackage

// File: rtl/supv_prescale.sv
module supv_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/supv_edge_sync.sv
module supv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic toggle
);
  // stage[0..STAGES-1] synchronise, stage[STAGES] holds the previous value
  logic [STAGES:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= 1'b0;
    else     stage_q[0] <= din;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= 1'b0;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign toggle = stage_q[STAGES] ^ stage_q[STAGES-1];
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
  import supv_pkg::*;
#(
  parameter int LONG_T  = 64,
  parameter int SHORT_T = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_en,
  input  logic toggle,
  input  logic short_sel,
  input  logic in_reset,
  output logic expire,
  output logic ok
);
  localparam int CW = $clog2(LONG_T + 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_T - 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_T - 1);

  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic          ok_q;
  logic          run;
  logic          svc;
  wd_period_e    per;
  logic [CW-1:0] lim_m1;

  assign run    = wd_en & supply_ok;
  assign svc    = toggle & supply_ok;
  assign per    = (long_q || !short_sel) ? PER_LONG : PER_SHORT;
  assign lim_m1 = (per == PER_LONG) ? LONG_M1 : SHORT_M1;
  assign expire = run && tick && !svc && (cnt_q >= lim_m1);
  assign ok     = ok_q;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (svc)     cnt_q <= '0;
    else if (expire)  cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !supply_ok)     long_q <= 1'b1;
    else if (expire)           long_q <= 1'b1;
    else if (svc && !in_reset) long_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) ok_q <= 1'b1;
    else if (svc)          ok_q <= 1'b1;
    else if (expire)       ok_q <= 1'b0;
  end
endmodule

// File: rtl/supv_rst_gen.sv
module supv_rst_gen #(
  parameter int ACT_T = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic trigger,
  output logic active
);
  localparam int AW = $clog2(ACT_T + 1);
  localparam logic [AW-1:0] LAST = AW'(ACT_T - 1);

  logic [AW-1:0] cnt_q;
  logic          act_q;

  assign active = act_q;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok || trigger) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && tick) begin
      if (cnt_q == LAST) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl #(
  parameter int PRESCALE_DIV   = 64,
  parameter int RST_ACT_TICKS  = 8,
  parameter int WD_LONG_TICKS  = 64,
  parameter int WD_SHORT_TICKS = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic on_batt,
  input  logic wd_in,
  input  logic wd_en,
  input  logic wd_short,
  input  logic ce_in_n,
  input  logic pf_in,
  output logic sys_rst_n,
  output logic sys_rst,
  output logic wdog_ok,
  output logic low_line_n,
  output logic mem_ce_n,
  output logic pfail_n
);
  logic supply_ok;
  logic tick;
  logic wd_toggle;
  logic wd_expire;
  logic pulse_active;
  logic rst_any;

  assign supply_ok = pwr_ok & ~on_batt;

  supv_prescale #(.DIV(PRESCALE_DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  supv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (wd_in),
    .toggle (wd_toggle)
  );

  supv_wdog #(.LONG_T(WD_LONG_TICKS), .SHORT_T(WD_SHORT_TICKS)) u_wd (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .supply_ok (supply_ok),
    .wd_en     (wd_en),
    .toggle    (wd_toggle),
    .short_sel (wd_short),
    .in_reset  (pulse_active),
    .expire    (wd_expire),
    .ok        (wdog_ok)
  );

  supv_rst_gen #(.ACT_T(RST_ACT_TICKS)) u_rg (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .supply_ok (supply_ok),
    .trigger   (wd_expire),
    .active    (pulse_active)
  );

  assign rst_any    = pulse_active | ~supply_ok;
  assign sys_rst    = rst_any;
  assign sys_rst_n  = ~rst_any;
  assign low_line_n = supply_ok;
  assign mem_ce_n   = supply_ok ? ce_in_n : 1'b1;
  assign pfail_n    = on_batt ? 1'b0 : pf_in;
endmodule

// File: rtl/supv_ctrl_chk.sv
module supv_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic pwr_ok,
  input logic on_batt,
  input logic wd_en,
  input logic ce_in_n,
  input logic pf_in,
  input logic sys_rst_n,
  input logic sys_rst,
  input logic wdog_ok,
  input logic low_line_n,
  input logic mem_ce_n,
  input logic pfail_n
);
  // R1
  bad_supply_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (!pwr_ok || on_batt) |-> (!sys_rst_n && sys_rst && !low_line_n));

  // R1
  rst_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst != sys_rst_n);

  // R2
  release_supply_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> $past(low_line_n));

  // R3
  expiry_resets_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wdog_ok) |-> sys_rst);

  // R5
  lowline_sets_ok_chk: assert property (@(posedge clk) disable iff (rst)
    !low_line_n |=> wdog_ok);

  // R7
  disabled_no_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wdog_ok) |-> $past(wd_en));

  // R8
  ce_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n == (low_line_n ? ce_in_n : 1'b1));

  // R9
  pfail_batt_chk: assert property (@(posedge clk) disable iff (rst)
    pfail_n == (on_batt ? 1'b0 : pf_in));
endmodule

bind supv_ctrl supv_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_ok     (pwr_ok),
  .on_batt    (on_batt),
  .wd_en      (wd_en),
  .ce_in_n    (ce_in_n),
  .pf_in      (pf_in),
  .sys_rst_n  (sys_rst_n),
  .sys_rst    (sys_rst),
  .wdog_ok    (wdog_ok),
  .low_line_n (low_line_n),
  .mem_ce_n   (mem_ce_n),
  .pfail_n    (pfail_n)
);

// File: tb/tb_supv_ctrl.sv
module tb_supv_ctrl;
  localparam int P  = 4;
  localparam int RT = 3;
  localparam int LT = 10;
  localparam int ST = 4;

  logic clk = 1'b0;
  logic rst, pwr_ok, on_batt, wd_in, wd_en, wd_short, ce_in_n, pf_in;
  logic sys_rst_n, sys_rst, wdog_ok, low_line_n, mem_ce_n, pfail_n;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  supv_ctrl #(
    .PRESCALE_DIV(P), .RST_ACT_TICKS(RT),
    .WD_LONG_TICKS(LT), .WD_SHORT_TICKS(ST), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .on_batt(on_batt),
    .wd_in(wd_in), .wd_en(wd_en), .wd_short(wd_short),
    .ce_in_n(ce_in_n), .pf_in(pf_in),
    .sys_rst_n(sys_rst_n), .sys_rst(sys_rst), .wdog_ok(wdog_ok),
    .low_line_n(low_line_n), .mem_ce_n(mem_ce_n), .pfail_n(pfail_n)
  );

  // {pwr_ok, on_batt, ce_in_n, pf_in, exp mem_ce_n, exp pfail_n, exp low_line_n}
  localparam logic [6:0] VEC [8] = '{
    7'b1000_001, 7'b1011_111, 7'b1001_011, 7'b1010_101,
    7'b0001_110, 7'b0010_100, 7'b1101_100, 7'b0100_100
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic edges_until(input logic want, input int lim, output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (sys_rst !== want && n < lim);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired: run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int t1, a, b, bad;
    rst = 1'b1; pwr_ok = 1'b0; on_batt = 1'b0; wd_in = 1'b0; wd_en = 1'b0;
    wd_short = 1'b0; ce_in_n = 1'b0; pf_in = 1'b1;
    step(3);
    // R10 reset state
    chk("R10 sys_rst_n", sys_rst_n, 0);
    chk("R10 sys_rst", sys_rst, 1);
    chk("R10 wdog_ok", wdog_ok, 1);
    chk("R1 low_line_n", low_line_n, 0);
    chk("R8 mem_ce_n", mem_ce_n, 1);
    @(negedge clk) rst = 1'b0;

    // R1 R8 R9 gating vectors
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {pwr_ok, on_batt, ce_in_n, pf_in} = VEC[i][6:3];
      #2;
      chk("R8 mem_ce_n", mem_ce_n, VEC[i][2]);
      chk("R9 pfail_n", pfail_n, VEC[i][1]);
      chk("R1 low_line_n", low_line_n, VEC[i][0]);
      if (!VEC[i][0]) chk("R1 sys_rst_n", sys_rst_n, 0);
    end
    @(negedge clk) begin on_batt = 1'b0; pwr_ok = 1'b0; ce_in_n = 1'b0; pf_in = 1'b1; end

    // R2 release window
    @(negedge clk) pwr_ok = 1'b1;
    step((RT - 1) * P);
    chk("R2 still held", sys_rst_n, 0);
    step(P);
    chk("R2 released", sys_rst_n, 1);

    // R7 disabled watchdog never expires
    bad = 0;
    for (int i = 0; i < 120; i++) begin
      step(1);
      if (wdog_ok !== 1'b1 || sys_rst_n !== 1'b1) bad++;
    end
    chk("R7 no expiry while disabled", bad, 0);

    // R3 long timeout after a service
    @(negedge clk) begin wd_en = 1'b1; wd_in = ~wd_in; end
    edges_until(1'b1, 200, t1);
    chk_win("R3 long expiry edge", t1, 3 + (LT - 1) * P + 1, 3 + LT * P);
    chk("R3 wdog_ok low", wdog_ok, 0);

    // R4 repeat every long period
    edges_until(1'b0, 200, a);
    edges_until(1'b1, 200, b);
    chk("R4 repeat gap", a + b, LT * P);
    chk("R5 wdog_ok stays low", wdog_ok, 0);

    // R5 R6 service then short period
    edges_until(1'b0, 200, a);
    @(negedge clk) begin wd_short = 1'b1; wd_in = ~wd_in; end
    step(2);
    chk("R5 wdog_ok before sync", wdog_ok, 0);
    step(1);
    chk("R5 wdog_ok after toggle", wdog_ok, 1);
    edges_until(1'b1, 200, t1);
    chk_win("R6 short expiry edge", t1 + 3, 3 + (ST - 1) * P + 1, 3 + ST * P);
    edges_until(1'b0, 200, a);
    edges_until(1'b1, 200, b);
    chk("R6 long after reset", a + b, LT * P);

    // R9 R5 battery mode
    @(negedge clk) begin on_batt = 1'b1; ce_in_n = 1'b0; pf_in = 1'b1; end
    #2;
    chk("R1 batt reset", sys_rst_n, 0);
    chk("R9 pfail_n batt", pfail_n, 0);
    chk("R8 mem_ce_n batt", mem_ce_n, 1);
    step(1);
    chk("R5 low line sets wdog_ok", wdog_ok, 1);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk) wd_in = ~wd_in;
      step(1);
      if (wdog_ok !== 1'b1 || sys_rst_n !== 1'b0 || pfail_n !== 1'b0 || mem_ce_n !== 1'b1) bad++;
    end
    chk("R9 wd_in ignored in battery", bad, 0);
    @(negedge clk) on_batt = 1'b0;
    step(RT * P);
    chk("R2 release after battery", sys_rst_n, 1);

    // R10 synchronous reset mid-run
    @(negedge clk) rst = 1'b1;
    step(1);
    chk("R10 rst asserts reset", sys_rst_n, 0);
    chk("R10 rst wdog_ok", wdog_ok, 1);
    @(negedge clk) rst = 1'b0;
    step(RT * P - 1);
    chk("R10 held before release", sys_rst_n, 0);
    step(1);
    chk("R10 exact release", sys_rst_n, 1);
    step(LT * P - RT * P - 1);
    chk("R10 no expiry yet", sys_rst, 0);
    step(1);
    chk("R6 first expiry long after rst", sys_rst, 1);
    chk("R3 wdog_ok after rst expiry", wdog_ok, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule